// File: doc/BRIEF.md
# Banked BCD Calendar Clock Core

This core keeps calendar time as one decimal digit per 4-bit register: seconds, minutes and hours (units and tens each), day of week, day and month (units and tens), and a four-digit year down to the thousands digit. It advances once for every cycle in which the one-hertz `tick` enable is high. Oscillator, prescaler and analog parts are outside the core.

A host reaches the registers through a 4-bit address and a 4-bit data bus, using read and write strobes. Register 0xF is a control register that is visible in every bank. It carries a busy flag, a stop bit and a two-bit bank number. Bank 0 maps the time digits. Bank 2 holds a two-bit timer control register. The selected bank and the timer control bits leave the core as ports, so that alarm and timer logic outside can use them.

A host reading the time first polls busy until it is clear. It then reads the digits.

Top module: `bcd_calendar_core`

## Requirements
- R1: Reset loads 2000-01-01 00:00:00 with day of week 6. It also clears stop, busy, bank number and timer control to zero.
- R2: In bank 0, addresses hold these digits: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 day of week, 7 day units, 8 day tens, 9 month units, 0xA month tens, 0xB year units, 0xC year tens, 0xD year hundreds, 0xE year thousands. `rdata` follows the addressed register combinationally while `rd_en` is 1 and is 0 otherwise.
- R3: Address 0xF in any bank reads {bank[1:0], stop, busy} from bit 3 down to bit 0. A write there sets stop from bit 1 and the bank from bits 3:2, and ignores bit 0. `bank_sel` shows the bank.
- R4: On a tick, seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R5: Day of week advances on each day carry and wraps from 6 to 0.
- R6: Day wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days in a leap year and 28 otherwise. The other months have 31 days. A year is a leap year if it is divisible by 4, except a century year, which is a leap year only if it is divisible by 400.
- R7: Month counts from 1 to 12. After 12 it wraps to 01 and carries into the year. The year counts in decimal from 0000 and wraps from 9999 to 0000.
- R8: While stop is 1, ticks do not change any time digit. Once stop is cleared, counting resumes.
- R9: Busy reads 1 in exactly the one cycle after a tick taken while running, and reads 0 after a tick taken while stopped. Writes to the digits during that busy cycle still take effect.
- R10: Bank 2 address 0xE is a read/write timer control register. Bit 0 is the interrupt enable and bit 1 is the flag. It resets to 0 and is driven onto `timer_ctrl`. In banks other than 0, every other address from 0x0 to 0xE reads 0 and ignores writes, and no write there changes any time digit.
- R11: If a digit write and a tick happen in the same cycle, the written digit takes the host value. The other digits advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-hertz advance enable, one cycle wide |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 4 | Read data, combinational |
| bank_sel | output | 2 | Currently selected bank |
| timer_ctrl | output | 2 | Timer control bits {flag, enable} |

## Verification
A wrong carry or month-length decision stays hidden until a tick crosses that boundary. In the cycle right after that tick, a read of bank 0 shows a wrong digit, so the bench loads the digits just below each boundary and reads all fifteen registers after one tick. Each wrong busy, stop or bank state shows up in one control read, one cycle after the stimulus. A write leaking into another bank shows up as a changed digit the next time bank 0 is selected.

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [3:0] rdata,
  output logic [1:0] bank_sel,
  output logic [1:0] timer_ctrl
);
  logic [3:0] dg [15];
  logic [3:0] nx [15];
  logic       stop_q, busy_q;
  logic [1:0] bank_q, tmr_q;
  logic [6:0] day_n, mon_n, yy_n, cc_n;
  logic [6:0] dim;
  logic       leap;

  wire run     = tick & ~stop_q;
  wire c_s0    = dg[0] == 4'd9;
  wire sec_end = c_s0 && dg[1] == 4'd5;
  wire c_m0    = sec_end && dg[2] == 4'd9;
  wire min_end = c_m0 && dg[3] == 4'd5;
  wire hr_end  = min_end && dg[5] == 4'd2 && dg[4] == 4'd3;
  wire day_end = hr_end && day_n == dim;
  wire mon_end = day_end && mon_n == 7'd12;
  wire dig_wr  = wr_en && bank_q == 2'd0 && addr != 4'hF;

  assign bank_sel   = bank_q;
  assign timer_ctrl = tmr_q;

  always_comb begin
    day_n = 7'(dg[8]) * 7'd10 + 7'(dg[7]);
    mon_n = 7'(dg[10]) * 7'd10 + 7'(dg[9]);
    yy_n  = 7'(dg[12]) * 7'd10 + 7'(dg[11]);
    cc_n  = 7'(dg[14]) * 7'd10 + 7'(dg[13]);
    leap  = (yy_n == 7'd0) ? (cc_n[1:0] == 2'd0) : (yy_n[1:0] == 2'd0);
    case (mon_n)
      7'd2:                    dim = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: dim = 7'd30;
      default:                 dim = 7'd31;
    endcase
  end

  always_comb begin
    for (int i = 0; i < 15; i++) nx[i] = dg[i];
    nx[0] = c_s0 ? 4'd0 : dg[0] + 4'd1;
    if (c_s0)    nx[1] = (dg[1] == 4'd5) ? 4'd0 : dg[1] + 4'd1;
    if (sec_end) nx[2] = (dg[2] == 4'd9) ? 4'd0 : dg[2] + 4'd1;
    if (c_m0)    nx[3] = (dg[3] == 4'd5) ? 4'd0 : dg[3] + 4'd1;
    if (min_end) begin
      if (hr_end) begin
        nx[4] = 4'd0; nx[5] = 4'd0;
      end else if (dg[4] == 4'd9) begin
        nx[4] = 4'd0; nx[5] = dg[5] + 4'd1;
      end else nx[4] = dg[4] + 4'd1;
    end
    if (hr_end) begin
      nx[6] = (dg[6] >= 4'd6) ? 4'd0 : dg[6] + 4'd1;
      if (day_end) begin
        nx[7] = 4'd1; nx[8] = 4'd0;
      end else if (dg[7] == 4'd9) begin
        nx[7] = 4'd0; nx[8] = dg[8] + 4'd1;
      end else nx[7] = dg[7] + 4'd1;
    end
    if (day_end) begin
      if (mon_end) begin
        nx[9] = 4'd1; nx[10] = 4'd0;
      end else if (dg[9] == 4'd9) begin
        nx[9] = 4'd0; nx[10] = dg[10] + 4'd1;
      end else nx[9] = dg[9] + 4'd1;
    end
    if (mon_end) begin
      nx[11] = (dg[11] == 4'd9) ? 4'd0 : dg[11] + 4'd1;
      if (dg[11] == 4'd9) begin
        nx[12] = (dg[12] == 4'd9) ? 4'd0 : dg[12] + 4'd1;
        if (dg[12] == 4'd9) begin
          nx[13] = (dg[13] == 4'd9) ? 4'd0 : dg[13] + 4'd1;
          if (dg[13] == 4'd9) nx[14] = (dg[14] == 4'd9) ? 4'd0 : dg[14] + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 15; i++) dg[i] <= 4'd0;
      dg[6]  <= 4'd6;
      dg[7]  <= 4'd1;
      dg[9]  <= 4'd1;
      dg[14] <= 4'd2;
      stop_q <= 1'b0;
      busy_q <= 1'b0;
      bank_q <= 2'd0;
      tmr_q  <= 2'd0;
    end else begin
      busy_q <= run;
      if (run) for (int i = 0; i < 15; i++) dg[i] <= nx[i];
      if (dig_wr) dg[addr] <= wdata;
      if (wr_en && addr == 4'hF) begin
        stop_q <= wdata[1];
        bank_q <= wdata[3:2];
      end
      if (wr_en && bank_q == 2'd2 && addr == 4'hE) tmr_q <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = 4'd0;
    if (rd_en) begin
      if (addr == 4'hF)                        rdata = {bank_q, stop_q, busy_q};
      else if (bank_q == 2'd0)                 rdata = dg[addr];
      else if (bank_q == 2'd2 && addr == 4'hE) rdata = {2'b00, tmr_q};
    end
  end

  AST_BUSY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) run |=> busy_q); // R9
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !busy_q); // R9
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> ($stable(dg[0]) && $stable(dg[7]) && $stable(dg[11]))); // R8
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_en && sec_end) |=> (dg[0] == 4'd0 && dg[1] == 4'd0)); // R4
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_en && hr_end && dg[6] == 4'd6) |=> dg[6] == 4'd0); // R5
  AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_en && mon_end) |=> (dg[9] == 4'd1 && dg[10] == 4'd0)); // R7
  AST_TIMER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bank_q == 2'd2 && addr == 4'hE) |=> $stable(tmr_q)); // R10
endmodule

// File: tb/sim_bcd_calendar_core.sv
module sim_bcd_calendar_core;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0, wdata = 0;
  logic [3:0] rdata;
  logic [1:0] bank_sel, timer_ctrl;
  int checks = 0, failures = 0;
  bit done = 0;

  bcd_calendar_core u0 (.clk, .rst_n, .tick, .addr, .wdata, .wr_en, .rd_en,
                        .rdata, .bank_sel, .timer_ctrl);

  always #2 clk = ~clk;

  // packed time: {year[15:0], month[7:0], day[7:0], hour, min, sec, dow[3:0]}
  localparam int NV = 15;
  localparam logic [59:0] VEC [NV][2] = '{
    '{60'h2000_01_01_00_00_00_6, 60'h2000_01_01_00_00_01_6},
    '{60'h2000_01_01_00_00_59_6, 60'h2000_01_01_00_01_00_6},
    '{60'h2000_01_01_00_59_59_6, 60'h2000_01_01_01_00_00_6},
    '{60'h2000_01_01_23_59_59_6, 60'h2000_01_02_00_00_00_0},
    '{60'h2023_02_28_23_59_59_2, 60'h2023_03_01_00_00_00_3},
    '{60'h2024_02_28_23_59_59_3, 60'h2024_02_29_00_00_00_4},
    '{60'h2024_02_29_23_59_59_4, 60'h2024_03_01_00_00_00_5},
    '{60'h1900_02_28_23_59_59_3, 60'h1900_03_01_00_00_00_4},
    '{60'h2000_02_28_23_59_59_1, 60'h2000_02_29_00_00_00_2},
    '{60'h2023_04_30_23_59_59_0, 60'h2023_05_01_00_00_00_1},
    '{60'h2023_12_31_23_59_59_0, 60'h2024_01_01_00_00_00_1},
    '{60'h9999_12_31_23_59_59_5, 60'h0000_01_01_00_00_00_6},
    '{60'h2023_01_19_09_59_59_4, 60'h2023_01_19_10_00_00_4},
    '{60'h2023_01_31_23_59_59_2, 60'h2023_02_01_00_00_00_3},
    '{60'h2023_09_30_23_59_59_6, 60'h2023_10_01_00_00_00_0}
  };

  function automatic int nib(input int a);
    return (a <= 5) ? a + 1 : (a == 6) ? 0 : a;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_here(input logic [3:0] a, output logic [3:0] d);
    addr = a; rd_en = 1; #1; d = rdata; rd_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); rd_here(a, d);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic load(input logic [59:0] v);
    for (int a = 0; a < 15; a++) wr(4'(a), v[nib(a)*4 +: 4]);
  endtask

  task automatic read_all(output logic [59:0] v);
    logic [3:0] d;
    v = '0;
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), d);
      v[nib(a)*4 +: 4] = d;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [59:0] v;
    logic [3:0] d, s0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    read_all(v);
    chk("R1 reset time", 64'(v), 64'(60'h2000_01_01_00_00_00_6));
    rd(4'hF, d);
    chk("R1 reset control", 64'(d), 64'h0);
    chk("R1 reset timer", 64'(timer_ctrl), 64'h0);
    chk("R1 reset bank", 64'(bank_sel), 64'h0);
    // R2 no strobe reads zero
    @(negedge clk); addr = 4'h6; #1;
    chk("R2 rdata idle", 64'(rdata), 64'h0);

    // table walk R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      load(VEC[i][0]);
      do_tick();
      read_all(v);
      chk($sformatf("R4/R5/R6/R7 vector %0d", i), 64'(v), 64'(VEC[i][1]));
    end

    // R9 busy pulse, write during busy
    load(60'h2023_06_15_12_30_20_4);
    do_tick();
    rd_here(4'hF, d);
    chk("R9 busy after tick", 64'(d), 64'h1);
    wdata = 4'd7; addr = 4'h0; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd_here(4'hF, d);
    chk("R9 busy cleared", 64'(d), 64'h0);
    rd(4'h0, d);
    chk("R9 write during busy", 64'(d), 64'h7);

    // R11 write and tick together
    wr(4'h0, 4'd5);
    @(negedge clk); tick = 1; wr_en = 1; addr = 4'h0; wdata = 4'd3;
    @(negedge clk); tick = 0; wr_en = 0;
    rd(4'h0, d);
    chk("R11 write wins", 64'(d), 64'h3);
    rd(4'h1, d);
    chk("R11 other digit", 64'(d), 64'h2);

    // R8 stop
    wr(4'hF, 4'b0010);
    rd(4'hF, d);
    chk("R3 control stop", 64'(d), 64'h2);
    do_tick();
    rd_here(4'hF, d);
    chk("R9 no busy when stopped", 64'(d), 64'h2);
    do_tick();
    rd(4'h0, d);
    chk("R8 frozen", 64'(d), 64'h3);
    wr(4'hF, 4'b0001);
    rd(4'hF, d);
    chk("R3 busy bit read only", 64'(d), 64'h0);
    do_tick();
    rd(4'h0, d);
    chk("R8 resumed", 64'(d), 64'h4);

    // R10 banks
    wr(4'hF, 4'b1000);
    chk("R3 bank port", 64'(bank_sel), 64'h2);
    rd(4'hF, d);
    chk("R3 control bank read", 64'(d), 64'h8);
    wr(4'hE, 4'd3);
    rd(4'hE, d);
    chk("R10 timer read", 64'(d), 64'h3);
    chk("R10 timer port", 64'(timer_ctrl), 64'h3);
    rd(4'h0, d);
    chk("R10 bank2 other reads zero", 64'(d), 64'h0);
    wr(4'hF, 4'b0100);
    wr(4'h0, 4'd9);
    wr(4'hE, 4'd0);
    rd(4'hE, d);
    chk("R10 bank1 reads zero", 64'(d), 64'h0);
    chk("R10 timer untouched", 64'(timer_ctrl), 64'h3);
    wr(4'hF, 4'b0000);
    rd(4'h0, d);
    chk("R10 digit untouched", 64'(d), 64'h4);
    rd(4'hE, d);
    chk("R10 year untouched", 64'(d), 64'h2);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule